// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the software-visible configuration of a four-bank SDRAM controller. The host reaches it through two ports. Writing the index port stores an internal offset. Later accesses to the data port then read or write the register at that offset. The register set covers two error-status words that software clears bit by bit, an error address, a controller configuration word and its read-only status, refresh and power-management timers, one configuration word per bank, a timing word, an ECC configuration word and an ECC error-status word. Most writable registers keep only the bits defined by their own write mask.

Each bank word carries three fields: a base address on an 8 MiB grid, a 3-bit size code and an enable bit. A bank counts as mapped only when its enable bit is set and the global enable bit of the configuration word is also set. The block compares a probe address against every mapped bank's window and reports a per-bank hit. It also drives an ECC interrupt that follows the ECC error-status word.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: Writing the index port (`host_port`=0) stores `host_wdata[7:0]` as the offset. A read of the index port returns it zero-extended. The data port (`host_port`=1) accesses the register at the stored offset. An offset that matches no register reads zero, and a write to it changes nothing.
- R2: After reset, the refresh timer (0x30) reads 0x05F00000, the power-management timer (0x34) reads 0x07C00000, the timing word (0x80) reads 0x00854009 and the configuration word (0x20) reads 0x00800000. Every other offset reads zero, and `ecc_irq`, `bank_map` and `bank_hit` are all zero.
- R3: The error-status words at 0x00 and 0x08 are write-1-to-clear. A one bit on `err0_set` or `err1_set` sets the matching bit. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: The error address at 0x10 stores all 32 written bits.
- R5: The configuration word at 0x20 stores all 32 written bits. The status word at 0x24 ignores writes.
- R6: A configuration write that changes bit 31 from 0 to 1 clears status bit 31. A write that changes it from 1 to 0 sets status bit 31. A write that leaves bit 31 unchanged leaves status bit 31 unchanged.
- R7: A configuration write that changes bit 30 from 0 to 1 sets status bit 30. A write that changes it from 1 to 0 clears status bit 30. Otherwise status bit 30 holds.
- R8: Stored values are masked as follows: the refresh timer (0x30) keeps write & 0x3FF80000, the timing word (0x80) keeps write & 0x018FC01F, and ECC configuration (0x94) keeps write & 0x00F00000.
- R9: The power-management timer (0x34) stores (write & 0xF8000000) | 0x07C00000.
- R10: Bank words live at offsets 0x40, 0x44, 0x48 and 0x4C, for banks 0 to 3. Each stores write & 0xFFDEE001.
- R11: `bank_map[i]` is 1 exactly when bit 0 of bank word i is set and configuration bit 31 is set.
- R12: `bank_hit[i]` is 1 when bank i is mapped, its size code (bits 19:17) is not 7, and base ≤ `probe_addr` < base + (4 MiB << code). The base is the bank word with bits 22:0 cleared. The window is computed without 32-bit wrap.
- R13: The ECC error-status word at 0x98 stores the full written value. `ecc_irq` rises on a write that takes the word from zero to nonzero, falls on a write of zero, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected port (combinational) |
| err0_set | input | 32 | Per-bit set pulses for error status word 0 |
| err1_set | input | 32 | Per-bit set pulses for error status word 1 |
| probe_addr | input | 32 | Address compared against the bank windows |
| bank_map | output | 4 | Per-bank mapped flag |
| bank_hit | output | 4 | Per-bank probe hit |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Every register, including the ECC interrupt flop, is written on the same clock edge that samples `host_wr` or a set pulse. The new value therefore appears on `host_rdata`, `ecc_irq` and `bank_map` one edge after the stimulus, and `bank_hit` also reacts combinationally to `probe_addr`. The bench drives each stimulus on a falling edge and samples at the next falling edge, so every result is observed half a cycle after the edge that makes it due. Index-port writes land on the same edge, so a data-port read is taken only after that edge. The bank sweep runs every size code on every bank and probes both sides of each window boundary.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_ERR0    = 8'h00;
  localparam logic [7:0] OFS_ERR1    = 8'h08;
  localparam logic [7:0] OFS_ERRADDR = 8'h10;
  localparam logic [7:0] OFS_CFG     = 8'h20;
  localparam logic [7:0] OFS_STAT    = 8'h24;
  localparam logic [7:0] OFS_RFSH    = 8'h30;
  localparam logic [7:0] OFS_PMT     = 8'h34;
  localparam logic [7:0] OFS_BANK0   = 8'h40;
  localparam logic [7:0] OFS_TIM     = 8'h80;
  localparam logic [7:0] OFS_ECCCFG  = 8'h94;
  localparam logic [7:0] OFS_ECCERR  = 8'h98;

  localparam logic [DATA_W-1:0] MASK_RFSH   = 32'h3FF8_0000;
  localparam logic [DATA_W-1:0] MASK_TIM    = 32'h018F_C01F;
  localparam logic [DATA_W-1:0] MASK_ECCCFG = 32'h00F0_0000;
  localparam logic [DATA_W-1:0] MASK_BANK   = 32'hFFDE_E001;
  localparam logic [DATA_W-1:0] MASK_PMT    = 32'hF800_0000;
  localparam logic [DATA_W-1:0] FORCE_PMT   = 32'h07C0_0000;

  localparam logic [DATA_W-1:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [DATA_W-1:0] RST_TIM  = 32'h0085_4009;
  localparam logic [DATA_W-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DATA_W-1:0] RST_PMT  = 32'h07C0_0000;

  // Control bits of the configuration word
  localparam int CFG_GLB_BIT = 31;
  localparam int CFG_AUX_BIT = 30;

  typedef struct packed {
    logic err0;
    logic err1;
    logic erraddr;
    logic cfg;
    logic stat;
    logic rfsh;
    logic pmt;
    logic tim;
    logic ecccfg;
    logic eccerr;
  } reg_sel_t;

  // Window length in bytes for a 3-bit size code, 33 bits wide to avoid wrap
  function automatic logic [DATA_W:0] bank_span(input logic [2:0] code);
    bank_span = (DATA_W+1)'(33'h0_0040_0000) << code;
  endfunction
endpackage

// File: rtl/sdram_cfg_index.sv
module sdram_cfg_index
  import sdram_cfg_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int NUM_BANKS   = 4,
  parameter int BANK_STRIDE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_wr,
  input  logic [IDX_W-1:0]     idx_wdata,
  output logic [IDX_W-1:0]     idx_q,
  output reg_sel_t             sel,
  output logic [NUM_BANKS-1:0] bank_sel
);
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (idx_wr) idx_d = idx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_comb begin
    sel.err0    = (idx_q == IDX_W'(OFS_ERR0));
    sel.err1    = (idx_q == IDX_W'(OFS_ERR1));
    sel.erraddr = (idx_q == IDX_W'(OFS_ERRADDR));
    sel.cfg     = (idx_q == IDX_W'(OFS_CFG));
    sel.stat    = (idx_q == IDX_W'(OFS_STAT));
    sel.rfsh    = (idx_q == IDX_W'(OFS_RFSH));
    sel.pmt     = (idx_q == IDX_W'(OFS_PMT));
    sel.tim     = (idx_q == IDX_W'(OFS_TIM));
    sel.ecccfg  = (idx_q == IDX_W'(OFS_ECCCFG));
    sel.eccerr  = (idx_q == IDX_W'(OFS_ECCERR));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
    localparam logic [IDX_W-1:0] B_OFS = IDX_W'(OFS_BANK0) + IDX_W'(b * BANK_STRIDE);
    assign bank_sel[b] = (idx_q == B_OFS);
  end

  // R1: the offset only moves on an index-port write
  a_r1_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q));
  a_r1_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(idx_wdata)));
endmodule

// File: rtl/sdram_cfg_bank.sv
module sdram_cfg_bank
  import sdram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              glb_en,
  input  logic [DATA_W-1:0] probe_addr,
  output logic [DATA_W-1:0] bank_q,
  output logic              mapped,
  output logic              hit
);
  logic [DATA_W-1:0] bank_d;
  logic [DATA_W:0]   base_ext;
  logic [DATA_W:0]   limit_ext;
  logic [DATA_W:0]   probe_ext;
  logic [2:0]        size_code;

  always_comb begin
    bank_d = bank_q;
    if (wr_en) bank_d = wdata & MASK_BANK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  always_comb begin
    size_code = bank_q[19:17];
    base_ext  = {1'b0, bank_q[31:23], 23'b0};
    limit_ext = base_ext + bank_span(size_code);
    probe_ext = {1'b0, probe_addr};
    mapped    = bank_q[0] & glb_en;
    hit       = mapped && (size_code != 3'd7) &&
                (probe_ext >= base_ext) && (probe_ext < limit_ext);
  end

  // R11: nothing is mapped while the controller is globally off
  a_r11_off_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !mapped);
  // R12: a hit never comes from an unmapped bank
  a_r12_hit_needs_map: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> mapped);
endmodule

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              eccerr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] eccerr_q,
  output logic              ecc_irq,
  output logic              glb_en
);
  logic [DATA_W-1:0] cfg_d;
  logic [DATA_W-1:0] stat_d;
  logic [DATA_W-1:0] eccerr_d;
  logic              irq_d;

  always_comb begin
    cfg_d  = cfg_q;
    stat_d = stat_q;
    if (cfg_wr) begin
      cfg_d = wdata;
      if (!cfg_q[CFG_GLB_BIT] && wdata[CFG_GLB_BIT])      stat_d[CFG_GLB_BIT] = 1'b0;
      else if (cfg_q[CFG_GLB_BIT] && !wdata[CFG_GLB_BIT]) stat_d[CFG_GLB_BIT] = 1'b1;
      if (!cfg_q[CFG_AUX_BIT] && wdata[CFG_AUX_BIT])      stat_d[CFG_AUX_BIT] = 1'b1;
      else if (cfg_q[CFG_AUX_BIT] && !wdata[CFG_AUX_BIT]) stat_d[CFG_AUX_BIT] = 1'b0;
    end
  end

  always_comb begin
    eccerr_d = eccerr_q;
    irq_d    = ecc_irq;
    if (eccerr_wr) begin
      eccerr_d = wdata;
      if ((eccerr_q == '0) && (wdata != '0))      irq_d = 1'b1;
      else if ((eccerr_q != '0) && (wdata == '0)) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= RST_CFG;
      stat_q   <= '0;
      eccerr_q <= '0;
      ecc_irq  <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      stat_q   <= stat_d;
      eccerr_q <= eccerr_d;
      ecc_irq  <= irq_d;
    end
  end

  assign glb_en = cfg_q[CFG_GLB_BIT];

  a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_q[CFG_GLB_BIT] && wdata[CFG_GLB_BIT]) |=> !stat_q[CFG_GLB_BIT]);
  a_r6_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_q[CFG_GLB_BIT] && !wdata[CFG_GLB_BIT]) |=> stat_q[CFG_GLB_BIT]);
  a_r7_aux_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_q[CFG_AUX_BIT] != wdata[CFG_AUX_BIT])) |=>
      (stat_q[CFG_AUX_BIT] == $past(wdata[CFG_AUX_BIT])));
  a_r13_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (eccerr_wr && (eccerr_q == '0) && (wdata != '0)) |=> ecc_irq);
  a_r13_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (eccerr_wr && (wdata == '0)) |=> !ecc_irq);
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int IDX_W       = 8,
  parameter int BANK_STRIDE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_port,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  input  logic [DATA_W-1:0]    err0_set,
  input  logic [DATA_W-1:0]    err1_set,
  input  logic [DATA_W-1:0]    probe_addr,
  output logic [NUM_BANKS-1:0] bank_map,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 ecc_irq
);
  // Asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic                 idx_wr;
  logic                 data_wr;
  logic [IDX_W-1:0]     idx_q;
  reg_sel_t             sel;
  logic [NUM_BANKS-1:0] bank_sel;

  assign idx_wr  = host_wr & ~host_port;
  assign data_wr = host_wr &  host_port;

  sdram_cfg_index #(
    .IDX_W      (IDX_W),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_STRIDE(BANK_STRIDE)
  ) u_index (
    .clk      (clk),
    .rst_n    (rst_q),
    .idx_wr   (idx_wr),
    .idx_wdata(host_wdata[IDX_W-1:0]),
    .idx_q    (idx_q),
    .sel      (sel),
    .bank_sel (bank_sel)
  );

  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] eccerr_q;
  logic              glb_en;

  sdram_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q),
    .cfg_wr   (data_wr & sel.cfg),
    .eccerr_wr(data_wr & sel.eccerr),
    .wdata    (host_wdata),
    .cfg_q    (cfg_q),
    .stat_q   (stat_q),
    .eccerr_q (eccerr_q),
    .ecc_irq  (ecc_irq),
    .glb_en   (glb_en)
  );

  logic [DATA_W-1:0] bank_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_cfg_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_q),
      .wr_en     (data_wr & bank_sel[b]),
      .wdata     (host_wdata),
      .glb_en    (glb_en),
      .probe_addr(probe_addr),
      .bank_q    (bank_word[b]),
      .mapped    (bank_map[b]),
      .hit       (bank_hit[b])
    );
  end

  // Plain registers: error words, error address, timers, timing, ECC config
  logic [DATA_W-1:0] err0_q, err0_d;
  logic [DATA_W-1:0] err1_q, err1_d;
  logic [DATA_W-1:0] erraddr_q, erraddr_d;
  logic [DATA_W-1:0] rfsh_q, rfsh_d;
  logic [DATA_W-1:0] pmt_q, pmt_d;
  logic [DATA_W-1:0] tim_q, tim_d;
  logic [DATA_W-1:0] ecccfg_q, ecccfg_d;
  logic [DATA_W-1:0] clr0, clr1;

  always_comb begin
    clr0      = (data_wr && sel.err0) ? host_wdata : '0;
    clr1      = (data_wr && sel.err1) ? host_wdata : '0;
    err0_d    = (err0_q & ~clr0) | err0_set;
    err1_d    = (err1_q & ~clr1) | err1_set;
    erraddr_d = erraddr_q;
    rfsh_d    = rfsh_q;
    pmt_d     = pmt_q;
    tim_d     = tim_q;
    ecccfg_d  = ecccfg_q;
    if (data_wr) begin
      if (sel.erraddr) erraddr_d = host_wdata;
      if (sel.rfsh)    rfsh_d    = host_wdata & MASK_RFSH;
      if (sel.pmt)     pmt_d     = (host_wdata & MASK_PMT) | FORCE_PMT;
      if (sel.tim)     tim_d     = host_wdata & MASK_TIM;
      if (sel.ecccfg)  ecccfg_d  = host_wdata & MASK_ECCCFG;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      err0_q    <= '0;
      err1_q    <= '0;
      erraddr_q <= '0;
      rfsh_q    <= RST_RFSH;
      pmt_q     <= RST_PMT;
      tim_q     <= RST_TIM;
      ecccfg_q  <= '0;
    end else begin
      err0_q    <= err0_d;
      err1_q    <= err1_d;
      erraddr_q <= erraddr_d;
      rfsh_q    <= rfsh_d;
      pmt_q     <= pmt_d;
      tim_q     <= tim_d;
      ecccfg_q  <= ecccfg_d;
    end
  end

  // Read multiplexer; an unknown offset leaves it at zero
  always_comb begin
    host_rdata = '0;
    if (!host_port) begin
      host_rdata[IDX_W-1:0] = idx_q;
    end else begin
      if (sel.err0)    host_rdata = err0_q;
      if (sel.err1)    host_rdata = err1_q;
      if (sel.erraddr) host_rdata = erraddr_q;
      if (sel.cfg)     host_rdata = cfg_q;
      if (sel.stat)    host_rdata = stat_q;
      if (sel.rfsh)    host_rdata = rfsh_q;
      if (sel.pmt)     host_rdata = pmt_q;
      if (sel.tim)     host_rdata = tim_q;
      if (sel.ecccfg)  host_rdata = ecccfg_q;
      if (sel.eccerr)  host_rdata = eccerr_q;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_sel[b]) host_rdata = bank_word[b];
      end
    end
  end

  // R3: a set pulse always lands, even against a same-cycle clear
  a_r3_set_wins0: assert property (@(posedge clk) disable iff (!rst_q)
    (err0_set != '0) |=> ((err0_q & $past(err0_set)) == $past(err0_set)));
  a_r3_set_wins1: assert property (@(posedge clk) disable iff (!rst_q)
    (err1_set != '0) |=> ((err1_q & $past(err1_set)) == $past(err1_set)));
  // R9: the forced field of the power-management timer never drops
  a_r9_pmt_forced: assert property (@(posedge clk) disable iff (!rst_q)
    data_wr && sel.pmt |=> ((pmt_q & FORCE_PMT) == FORCE_PMT));
endmodule

// File: tb/sdram_cfg_regfile_tb.sv
`timescale 1ns/1ps
module sdram_cfg_regfile_tb;
  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic        host_port;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [31:0] err0_set;
  logic [31:0] err1_set;
  logic [31:0] probe_addr;
  logic [3:0]  bank_map;
  logic [3:0]  bank_hit;
  logic        ecc_irq;

  int n_tests = 0;
  int n_fail  = 0;

  sdram_cfg_regfile u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_port (host_port),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .err0_set  (err0_set),
    .err1_set  (err1_set),
    .probe_addr(probe_addr),
    .bank_map  (bank_map),
    .bank_hit  (bank_hit),
    .ecc_irq   (ecc_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic port, input logic [31:0] d);
    @(negedge clk);
    host_port  = port;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ofs, input logic [31:0] d);
    host_write(1'b0, {24'h0, ofs});
    host_write(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] ofs, output logic [31:0] v);
    host_write(1'b0, {24'h0, ofs});
    host_port = 1'b1;
    #1 v = host_rdata;
  endtask

  function automatic bit is_defined(input int ofs);
    case (ofs)
      8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34,
      8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] reset_val(input int ofs);
    case (ofs)
      8'h20:   return 32'h0080_0000;
      8'h30:   return 32'h05F0_0000;
      8'h34:   return 32'h07C0_0000;
      8'h80:   return 32'h0085_4009;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] base;
    logic [32:0] span;
    logic [32:0] pe;
    logic [31:0] probes [4];
    logic [31:0] pats [3];

    host_wr = 0; host_port = 0; host_wdata = 0;
    err0_set = 0; err1_set = 0; probe_addr = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R2: outputs idle after reset
    check("R2 ecc_irq", {31'h0, ecc_irq}, 32'h0);
    check("R2 bank_map", {28'h0, bank_map}, 32'h0);
    check("R2 bank_hit", {28'h0, bank_hit}, 32'h0);

    // R2 / R1: every offset reads its reset value, unknown ones read zero
    for (int o = 0; o < 256; o++) begin
      reg_rd(8'(o), v);
      check(is_defined(o) ? "R2 reset value" : "R1 undefined reads zero", v, reset_val(o));
    end

    // R1: writes to unknown offsets change nothing
    for (int o = 0; o < 256; o++)
      if (!is_defined(o)) reg_wr(8'(o), 32'hFFFF_FFFF);
    for (int o = 0; o < 256; o++) begin
      reg_rd(8'(o), v);
      check("R1 undefined write ignored", v, reset_val(o));
    end

    // R1: the index port reads back the stored offset
    host_write(1'b0, 32'hFFFF_FF5A);
    host_port = 1'b0;
    #1 check("R1 index readback", host_rdata, 32'h0000_005A);

    // R4 / R8 / R9: masked stores under several patterns
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h1234_5678;
    for (int p = 0; p < 3; p++) begin
      reg_wr(8'h10, pats[p]); reg_rd(8'h10, v); check("R4 error address", v, pats[p]);
      reg_wr(8'h30, pats[p]); reg_rd(8'h30, v); check("R8 refresh mask", v, pats[p] & 32'h3FF8_0000);
      reg_wr(8'h80, pats[p]); reg_rd(8'h80, v); check("R8 timing mask", v, pats[p] & 32'h018F_C01F);
      reg_wr(8'h94, pats[p]); reg_rd(8'h94, v); check("R8 ecc cfg mask", v, pats[p] & 32'h00F0_0000);
      reg_wr(8'h34, pats[p]); reg_rd(8'h34, v);
      check("R9 pm timer", v, (pats[p] & 32'hF800_0000) | 32'h07C0_0000);
    end
    reg_wr(8'h34, 32'h0); reg_rd(8'h34, v); check("R9 pm timer zero", v, 32'h07C0_0000);

    // R5: status ignores writes
    reg_wr(8'h24, 32'hFFFF_FFFF); reg_rd(8'h24, v); check("R5 status read-only", v, 32'h0);

    // R5 / R6 / R7: configuration transitions
    reg_wr(8'h20, 32'h8000_0000); reg_rd(8'h24, v); check("R6 enable keeps clear", v, 32'h0);
    reg_rd(8'h20, v); check("R5 cfg stored", v, 32'h8000_0000);
    reg_wr(8'h20, 32'h0000_0000); reg_rd(8'h24, v); check("R6 disable sets bit31", v, 32'h8000_0000);
    reg_wr(8'h20, 32'h4000_0000); reg_rd(8'h24, v); check("R7 aux rise", v, 32'hC000_0000);
    reg_wr(8'h20, 32'hC000_0000); reg_rd(8'h24, v); check("R6 enable clears bit31", v, 32'h4000_0000);
    reg_wr(8'h20, 32'hC000_0000); reg_rd(8'h24, v); check("R6 R7 no transition", v, 32'h4000_0000);
    reg_wr(8'h20, 32'h8000_0000); reg_rd(8'h24, v); check("R7 aux fall", v, 32'h0);
    reg_wr(8'h20, 32'h1234_5678); reg_rd(8'h20, v); check("R5 cfg full word", v, 32'h1234_5678);
    reg_rd(8'h24, v); check("R6 disable again", v, 32'h8000_0000);
    reg_wr(8'h24, 32'h0); reg_rd(8'h24, v); check("R5 status write ignored", v, 32'h8000_0000);

    // R3: error words set by pulses, cleared by ones, set wins
    @(negedge clk); err0_set = 32'hF0F0_0001; err1_set = 32'h0000_0F00;
    @(negedge clk); err0_set = 0; err1_set = 0;
    reg_rd(8'h00, v); check("R3 err0 set", v, 32'hF0F0_0001);
    reg_rd(8'h08, v); check("R3 err1 set", v, 32'h0000_0F00);
    reg_wr(8'h00, 32'h00F0_0000); reg_rd(8'h00, v); check("R3 err0 w1c", v, 32'hF000_0001);
    reg_wr(8'h08, 32'h0000_0300); reg_rd(8'h08, v); check("R3 err1 w1c", v, 32'h0000_0C00);
    host_write(1'b0, 32'h0000_0000);
    @(negedge clk);
    host_port = 1'b1; host_wdata = 32'h1000_0001; host_wr = 1'b1; err0_set = 32'h0000_0001;
    @(negedge clk);
    host_wr = 1'b0; err0_set = 0;
    #1 check("R3 set beats clear", host_rdata, 32'hE000_0001);

    // R13: ECC error status and interrupt
    reg_wr(8'h98, 32'h0); check("R13 zero stays low", {31'h0, ecc_irq}, 32'h0);
    reg_wr(8'h98, 32'h0000_0005); check("R13 irq rises", {31'h0, ecc_irq}, 32'h1);
    reg_rd(8'h98, v); check("R13 value stored", v, 32'h0000_0005);
    reg_wr(8'h98, 32'hFFFF_0000); check("R13 irq holds", {31'h0, ecc_irq}, 32'h1);
    reg_rd(8'h98, v); check("R13 full word", v, 32'hFFFF_0000);
    reg_wr(8'h98, 32'h0); check("R13 irq falls", {31'h0, ecc_irq}, 32'h0);

    // R10 / R11: bank masks and mapping gate
    reg_wr(8'h20, 32'h0);
    for (int b = 0; b < 4; b++) begin
      reg_wr(8'(8'h40 + 4*b), 32'hFFFF_FFFF);
      reg_rd(8'(8'h40 + 4*b), v);
      check("R10 bank mask", v, 32'hFFDE_E001);
    end
    check("R11 global off", {28'h0, bank_map}, 32'h0);
    reg_wr(8'h20, 32'h8000_0000);
    check("R11 global on", {28'h0, bank_map}, 32'hF);
    reg_wr(8'h44, 32'hFFFF_FFFE);
    check("R11 bank enable off", {28'h0, bank_map}, 32'hD);

    // R11 / R12: sweep every bank and every size code
    for (int b = 0; b < 4; b++) begin
      for (int b2 = 0; b2 < 4; b2++) reg_wr(8'(8'h40 + 4*b2), 32'h0);
      for (int c = 0; c < 8; c++) begin
        base = 32'h2000_0000 + 32'(b) * 32'h1000_0000 + 32'(c) * 32'h0080_0000;
        span = 33'h0_0040_0000 << c;
        reg_wr(8'(8'h40 + 4*b), base | (32'(c) << 17) | 32'h1);
        check("R11 single bank mapped", {28'h0, bank_map}, 32'(1 << b));
        probes[0] = base - 1; probes[1] = base;
        probes[2] = 32'(33'(base) + span - 1); probes[3] = 32'(33'(base) + span);
        for (int k = 0; k < 4; k++) begin
          probe_addr = probes[k];
          pe = {1'b0, probes[k]};
          #1 check("R12 window",
                   {28'h0, bank_hit},
                   ((c != 7) && (pe >= {1'b0, base}) && (pe < {1'b0, base} + span)) ? 32'(1 << b) : 32'h0);
        end
      end
      probe_addr = base;
      reg_wr(8'(8'h40 + 4*b), base | (32'd2 << 17));
      check("R11 bank enable clear", {28'h0, bank_map}, 32'h0);
      check("R12 no hit when unmapped", {28'h0, bank_hit}, 32'h0);
    end

    // R12: top window beyond 4 GiB does not wrap; global off kills hits
    for (int b2 = 0; b2 < 4; b2++) reg_wr(8'(8'h40 + 4*b2), 32'h0);
    reg_wr(8'h4C, 32'hF800_0000 | (32'd6 << 17) | 32'h1);
    probe_addr = 32'hFFFF_FFFF;
    #1 check("R12 top window", {28'h0, bank_hit}, 32'h8);
    probe_addr = 32'h07FF_FFFF;
    #1 check("R12 no wrap", {28'h0, bank_hit}, 32'h0);
    probe_addr = 32'hF800_0000;
    reg_wr(8'h20, 32'h0);
    check("R11 global off unmaps", {28'h0, bank_map}, 32'h0);
    check("R12 global off no hit", {28'h0, bank_hit}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule